// File: doc/BRIEF.md
# Segmented Predicated Vector Minimum Reduction

This block takes one wide vector made of several 128-bit segments, a predicate mask with one bit per vector byte, an element-size code and a signed-mode flag. For every element position inside a 128-bit segment, it finds the smallest value that any segment holds at that position. Only active elements take part. The block returns one 128-bit word that holds one minimum per element position. Positions where no element is active return the identity of the minimum operation: all ones when unsigned, and the largest positive value when signed.

The vector width is a parameter and must be a multiple of 128. An operation is accepted on any cycle where `valid_in` is high, so a new operation can start every cycle. The result comes out on `result_out` with `valid_out` after a fixed two-cycle latency. The result stays on the output until the next result replaces it.

Top module: `seg_min_reduce`

## Requirements
- R1: `size_in` sets the element width to 8 << size_in bits: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 64. Element e of segment s is at vector bits s*128 + e*width and up. Result element e is at bits e*width and up of `result_out`.
- R2: When `signed_in` is 0, result element e is the unsigned minimum of element e over every segment whose copy of that element is active.
- R3: Element e of segment s is active exactly when predicate bit (s*(128/width) + e)*(width/8) is set. The other predicate bits under that element have no effect.
- R4: Inactive elements do not take part. A position with no active element in any segment returns all ones in unsigned mode.
- R5: If no predicate bit that selects an element is set, every result element is the identity value, whatever the vector holds.
- R6: When `signed_in` is 1, comparisons are two's-complement and the identity is 2^(width-1) - 1.
- R7: `valid_out` is high in exactly the cycles that follow, by two clock edges, the edges at which `valid_in` was high. Operations accepted on back-to-back cycles produce back-to-back results in the same order.
- R8: While `rst_n` is low, `valid_out` and `result_out` are 0. With no new result, `result_out` holds its last value and `valid_out` is low.
- R9: Every bit of `result_out` is rewritten by each result, so nothing from an earlier operation of another size remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Accept an operation this cycle |
| size_in | input | 2 | Element-size code |
| signed_in | input | 1 | 1 selects two's-complement comparison |
| vec_in | input | VLEN | Source vector, segment 0 in the low bits |
| pred_in | input | VLEN/8 | Predicate, one bit per vector byte |
| valid_out | output | 1 | Result valid |
| result_out | output | 128 | Per-position minima |

## Verification
Accepting a new operation and presenting the result of an earlier one can happen in the same cycle. Result hold and result update meet at the boundary between busy and idle cycles. The bench provokes both by streaming operations on every cycle, mixing sizes, signedness and predicates from one cycle to the next. Each result is checked two cycles after its operation, against a model computed in the bench. After each stream ends, the bench checks that `valid_out` drops and that the last result stays unchanged.

// File: rtl/segmin_pkg.sv
package segmin_pkg;

  localparam int SEG_W   = 128;
  localparam int N_SIZES = 4;

  typedef enum logic [1:0] {
    ESZ_B = 2'b00,
    ESZ_H = 2'b01,
    ESZ_W = 2'b10,
    ESZ_D = 2'b11
  } esize_e;

  typedef struct packed {
    logic   sgn;
    esize_e size;
  } op_ctl_t;

  function automatic int elem_bits(input int code);
    return 8 << code;
  endfunction

  function automatic int elems_per_seg(input int code);
    return SEG_W / elem_bits(code);
  endfunction

endpackage

// File: rtl/segmin_capture.sv
module segmin_capture
  import segmin_pkg::*;
#(
  parameter int VLEN = 512,
  localparam int PW  = VLEN / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_in,
  input  op_ctl_t         ctl_in,
  input  logic [VLEN-1:0] vec_in,
  input  logic [PW-1:0]   pred_in,
  output logic            s1_valid,
  output op_ctl_t         s1_ctl,
  output logic [VLEN-1:0] s1_vec,
  output logic [PW-1:0]   s1_pred
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_ctl   <= '0;
      s1_vec   <= '0;
      s1_pred  <= '0;
    end else begin
      s1_valid <= valid_in;
      if (valid_in) begin
        s1_ctl  <= ctl_in;
        s1_vec  <= vec_in;
        s1_pred <= pred_in;
      end
    end
  end

  assert_capture_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> s1_valid);
  assert_capture_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !s1_valid);

endmodule

// File: rtl/segmin_lane_unit.sv
module segmin_lane_unit
  import segmin_pkg::*;
#(
  parameter int VLEN  = 512,
  parameter int ESIZE = 8,
  localparam int SEGS  = VLEN / SEG_W,
  localparam int EPS   = SEG_W / ESIZE,
  localparam int NELEM = SEGS * EPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VLEN-1:0]  vec,
  input  logic [NELEM-1:0] act,
  input  logic             sgn,
  output logic [SEG_W-1:0] result,
  output logic             any_active
);

  // Map into a key domain where unsigned compare orders values correctly
  // for the chosen signedness; all-ones key is then the identity.
  function automatic logic [ESIZE-1:0] to_key(input logic [ESIZE-1:0] x,
                                               input logic s);
    return x ^ {s, {(ESIZE-1){1'b0}}};
  endfunction

  function automatic logic [ESIZE-1:0] from_key(input logic [ESIZE-1:0] k,
                                                 input logic s);
    return k ^ {s, {(ESIZE-1){1'b0}}};
  endfunction

  function automatic logic [ESIZE-1:0] identity(input logic s);
    return from_key({ESIZE{1'b1}}, s);
  endfunction

  assign any_active = |act;

  for (genvar e = 0; e < EPS; e++) begin : g_pos
    logic [ESIZE-1:0] acc;
    logic [ESIZE-1:0] cand;
    always_comb begin
      acc  = '1;
      cand = '0;
      for (int s = 0; s < SEGS; s++) begin
        cand = to_key(vec[s*SEG_W + e*ESIZE +: ESIZE], sgn);
        if (act[s*EPS + e] && (cand < acc)) begin
          acc = cand;
        end
      end
    end
    assign result[e*ESIZE +: ESIZE] = from_key(acc, sgn);
  end

  assert_idle_identity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !any_active |-> (result == {EPS{identity(sgn)}}));

  assert_seg0_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act[0] |-> (to_key(result[ESIZE-1:0], sgn) <= to_key(vec[ESIZE-1:0], sgn)));

endmodule

// File: rtl/seg_min_reduce.sv
module seg_min_reduce
  import segmin_pkg::*;
#(
  parameter int VLEN = 512,
  localparam int PW  = VLEN / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic [1:0]       size_in,
  input  logic             signed_in,
  input  logic [VLEN-1:0]  vec_in,
  input  logic [PW-1:0]    pred_in,
  output logic             valid_out,
  output logic [SEG_W-1:0] result_out
);

  op_ctl_t         ctl_in;
  logic            s1_valid;
  op_ctl_t         s1_ctl;
  logic [VLEN-1:0] s1_vec;
  logic [PW-1:0]   s1_pred;

  assign ctl_in = '{sgn: signed_in, size: esize_e'(size_in)};

  segmin_capture #(.VLEN(VLEN)) i_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_in (valid_in),
    .ctl_in   (ctl_in),
    .vec_in   (vec_in),
    .pred_in  (pred_in),
    .s1_valid (s1_valid),
    .s1_ctl   (s1_ctl),
    .s1_vec   (s1_vec),
    .s1_pred  (s1_pred)
  );

  logic [N_SIZES-1:0][SEG_W-1:0] lane_res;
  logic [N_SIZES-1:0]            lane_any;

  for (genvar k = 0; k < N_SIZES; k++) begin : g_size
    localparam int EB    = 8 << k;
    localparam int BPE   = EB / 8;
    localparam int NEL   = VLEN / EB;
    logic [NEL-1:0] act;
    // Only the predicate bit at the lowest byte of each element counts.
    for (genvar i = 0; i < NEL; i++) begin : g_act
      assign act[i] = s1_pred[i*BPE];
    end
    segmin_lane_unit #(.VLEN(VLEN), .ESIZE(EB)) i_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .vec        (s1_vec),
      .act        (act),
      .sgn        (s1_ctl.sgn),
      .result     (lane_res[k]),
      .any_active (lane_any[k])
    );
  end

  logic sel_any;
  assign sel_any = lane_any[s1_ctl.size];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out  <= 1'b0;
      result_out <= '0;
    end else begin
      valid_out <= s1_valid;
      if (s1_valid) begin
        result_out <= lane_res[s1_ctl.size];
      end
    end
  end

  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> valid_out);
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !valid_out);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(result_out));
  assert_empty_unsigned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !sel_any && !s1_ctl.sgn) |=> (result_out == '1));

endmodule

// File: tb/test_seg_min_reduce.sv
module test_seg_min_reduce;
  localparam int VLEN = 384;
  localparam int PW   = VLEN / 8;
  localparam int SEGS = VLEN / 128;
  localparam int MAXOPS = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid_in = 1'b0;
  logic [1:0]       size_in = '0;
  logic             signed_in = 1'b0;
  logic [VLEN-1:0]  vec_in = '0;
  logic [PW-1:0]    pred_in = '0;
  logic             valid_out;
  logic [127:0]     result_out;

  always #5 clk = ~clk;

  seg_min_reduce #(.VLEN(VLEN)) i_seg_min_reduce (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .size_in(size_in),
    .signed_in(signed_in), .vec_in(vec_in), .pred_in(pred_in),
    .valid_out(valid_out), .result_out(result_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  logic [1:0]      op_size [MAXOPS];
  logic            op_sgn  [MAXOPS];
  logic [VLEN-1:0] op_vec  [MAXOPS];
  logic [PW-1:0]   op_pred [MAXOPS];
  string           op_tag  [MAXOPS];
  int              nops = 0;
  logic [127:0]    last_exp = '0;

  function automatic logic [63:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  function automatic logic [VLEN-1:0] rand_vec();
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN/64; k++) v[k*64 +: 64] = next_rand();
    return v;
  endfunction

  function automatic logic [VLEN-1:0] extreme_vec();
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN/8; k++) begin
      case (next_rand() % 5)
        0: v[k*8 +: 8] = 8'h00;
        1: v[k*8 +: 8] = 8'h7F;
        2: v[k*8 +: 8] = 8'h80;
        3: v[k*8 +: 8] = 8'hFF;
        default: v[k*8 +: 8] = 8'h01;
      endcase
    end
    return v;
  endfunction

  function automatic logic [PW-1:0] rand_pred();
    logic [VLEN-1:0] t;
    t = rand_vec();
    return t[PW-1:0];
  endfunction

  function automatic logic [63:0] sext(input logic [63:0] x, input logic [63:0] sb);
    return (x ^ sb) - sb;
  endfunction

  // Arithmetic model built from the requirements (R1-style layout, R3 activity).
  function automatic logic [127:0] model(input logic [1:0] sz, input logic sg,
                                         input logic [VLEN-1:0] v,
                                         input logic [PW-1:0] p);
    int esz, eps;
    logic [63:0] mask, sb, x, best;
    logic [127:0] r;
    bit found, less;
    esz  = 8 << sz;
    eps  = 128 / esz;
    mask = (esz == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << esz) - 64'd1);
    sb   = 64'd1 << (esz - 1);
    r    = '0;
    for (int e = 0; e < eps; e++) begin
      found = 0;
      best  = '0;
      for (int s = 0; s < SEGS; s++) begin
        if (p[(s*eps + e) * (esz/8)]) begin
          x = 64'(v >> (s*128 + e*esz)) & mask;
          if (sg) less = $signed(sext(x, sb)) < $signed(sext(best, sb));
          else    less = x < best;
          if (!found || less) best = x;
          found = 1;
        end
      end
      if (!found) best = sg ? (mask >> 1) : mask;
      r = r | (128'(best & mask) << (e*esz));
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic add_op(input logic [1:0] sz, input logic sg,
                        input logic [VLEN-1:0] v, input logic [PW-1:0] p,
                        input string tag);
    op_size[nops] = sz; op_sgn[nops] = sg; op_vec[nops] = v;
    op_pred[nops] = p;  op_tag[nops] = tag;
    nops++;
  endtask

  // Back-to-back issue: op i is driven at negedge i, checked at negedge i+2.
  task automatic run_stream();
    logic [127:0] exp;
    for (int i = 0; i < nops + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        exp = model(op_size[i-2], op_sgn[i-2], op_vec[i-2], op_pred[i-2]);
        check("R7 valid_out", {127'd0, valid_out}, 128'd1);
        check(op_tag[i-2], result_out, exp);
        last_exp = exp;
      end
      if (i < nops) begin
        valid_in  = 1'b1;
        size_in   = op_size[i];
        signed_in = op_sgn[i];
        vec_in    = op_vec[i];
        pred_in   = op_pred[i];
      end else begin
        valid_in  = 1'b0;
        vec_in    = rand_vec();
        pred_in   = rand_pred();
      end
    end
    @(negedge clk);
    check("R8 idle valid_out", {127'd0, valid_out}, 128'd0);
    @(negedge clk);
    check("R8 hold result", result_out, last_exp);
    nops = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] nonlead;
    logic [PW-1:0] seg1;
    repeat (3) @(negedge clk);
    check("R8 reset valid_out", {127'd0, valid_out}, 128'd0);
    check("R8 reset result", result_out, 128'd0);
    rst_n = 1'b1;

    // Directed cases, streamed back to back with size/sign changes each cycle.
    for (int sz = 0; sz < 4; sz++) begin
      add_op(2'(sz), 1'b0, rand_vec(), '1, "R1 R2 all-active unsigned");
      add_op(2'(sz), 1'b1, rand_vec(), '1, "R6 all-active signed");
      add_op(2'(sz), 1'b0, rand_vec(), '0, "R5 no active unsigned");
      add_op(2'(sz), 1'b1, rand_vec(), '0, "R5 R6 no active signed");
      nonlead = '1;
      for (int b = 0; b < PW; b += (1 << sz)) nonlead[b] = 1'b0;
      add_op(2'(sz), 1'b0, rand_vec(), nonlead,
             (sz == 0) ? "R3 R4 byte size all cleared" : "R3 only non-lead bits set");
    end
    seg1 = '0;
    seg1[31:16] = '1;
    add_op(2'd0, 1'b0, rand_vec(), seg1, "R4 single segment active");
    add_op(2'd3, 1'b0, {VLEN{1'b1}}, '1, "R9 wide all ones");
    add_op(2'd0, 1'b0, '0, 48'h0000_0000_0001, "R9 narrow after wide");
    run_stream();

    // Near-exhaustive sweep of sizes x signedness with extreme byte values.
    for (int sz = 0; sz < 4; sz++)
      for (int sg = 0; sg < 2; sg++)
        for (int k = 0; k < 6; k++)
          add_op(2'(sz), 1'(sg), (k < 3) ? extreme_vec() : rand_vec(),
                 (k == 0) ? '1 : (rand_pred() | rand_pred()),
                 sg ? "R6 signed sweep" : "R2 R3 unsigned sweep");
    run_stream();

    // Single isolated operations with idle gaps around them.
    for (int k = 0; k < 8; k++) begin
      add_op(2'(k % 4), 1'(k / 4), extreme_vec(), rand_pred() & rand_pred(),
             "R7 isolated op");
      run_stream();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule